// File: doc/BRIEF.md
# Bipolar Return-to-Zero Avionics Word Receiver

This block takes the two comparator outputs of a self-clocked bipolar return-to-zero line, one for the positive level and one for the negative level, and turns them into 32-bit words. No clock travels with the data. Each bit is recovered from its own pulse: a positive pulse is a one and a negative pulse is a zero. Every pulse is followed by a return to the idle (NULL) level. Words are separated by long NULL stretches and not by start or stop bits.

The system clock oversamples the line. Both inputs are resynchronised before any decoding. A pulse counts as a bit once it has lasted a quarter of a bit period. A NULL of two bit periods ends framing: it throws away an unfinished word and re-arms the receiver after a full one. The word is assembled in arrival order. The 8-bit tag field arrives most significant bit first, so it can be flipped back into natural order on request. The word is presented with its status pair, its source/destination pair and an odd-parity verdict, and a one-cycle strobe marks it. Bit timing follows one of two line rates, picked by a configuration input.

Top module: `rz_word_rx`

## Requirements
- R1: A bit is taken when the positive input alone (value 1) or the negative input alone (value 0) stays asserted for MIN consecutive synchronised samples, where MIN is a quarter of the bit period in clock cycles. The pulse must follow at least one NULL sample. A shorter pulse yields no bit, and one pulse yields at most one bit.
- R2: A word is 32 bits long. The first bit to arrive lands in `rx_word[0]` and the n-th bit lands in `rx_word[n-1]`, except where R3 reorders the tag.
- R3: When `label_natural` is 1 at the moment a word completes, `rx_word[7:0]` and `label` carry the first eight bits in reversed order, so the first bit received becomes bit 7. When it is 0, they carry those bits as received.
- R4: `parity_err` is 1 when the 32 received bits hold an even number of ones, and 0 when they hold an odd number.
- R5: `sdi` carries received bits 9 and 10 (`rx_word[9:8]`). `ssm` carries received bits 30 and 31 (`rx_word[30:29]`).
- R6: With `rate_sel` at 0 the bit period is FAST_BIT_CYC clock cycles. With `rate_sel` at 1 it is SLOW_BIT_CYC clock cycles. Both the minimum pulse length and the gap length scale with the selected period, so pulses timed for the fast rate yield no bits at the slow rate.
- R7: Each synchronised sample with both inputs asserted raises `line_fault` for one cycle. Such a sample yields no bit and ends the current pulse.
- R8: A NULL of twice the bit period resets the bit count. A fragment of 1 to 31 bits is then discarded, and no `word_valid` is raised for it.
- R9: Each bit that arrives after the 32nd bit and before a gap pulses `frame_err` for one cycle. Such a bit leaves the presented word unchanged.
- R10: `word_valid` is high for exactly one cycle per completed word, in the cycle after the 32nd bit is taken. All word outputs hold their values until the next word completes.
- R11: Both line inputs pass through a two-stage synchroniser. After reset all outputs are 0, and no bit is taken before the line has shown a NULL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the line |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 1 | 0 selects the fast bit period, 1 selects the slow bit period |
| label_natural | input | 1 | 1 presents the tag field in natural bit order |
| line_hi | input | 1 | Positive-level comparator output, asynchronous |
| line_lo | input | 1 | Negative-level comparator output, asynchronous |
| word_valid | output | 1 | One-cycle strobe for a completed word |
| rx_word | output | 32 | Assembled word, tag order per `label_natural` |
| label | output | 8 | Tag field, same as `rx_word[7:0]` |
| sdi | output | 2 | Source/destination pair |
| ssm | output | 2 | Status pair |
| parity_err | output | 1 | Word failed odd parity |
| frame_err | output | 1 | One-cycle pulse for each bit beyond the 32nd |
| line_fault | output | 1 | Both comparators asserted together |

## Verification
The hardest states to reach from the ports are those where the bit count is not at a word boundary when a gap arrives, and those where the count has already passed 32 when another pulse comes in. A well-formed transmitter never produces either. The stimulus task therefore takes an explicit bit count: it sends a 20-bit fragment followed by a gap, and a 34-bit burst with no gap inside it. The bench then checks that exactly one word, the right one, appears, and that the extra bits show up only on the frame error pulse. Short pulses of one sample less than the minimum, both-asserted samples, and fast-timed pulses sent while the slow rate is selected probe the edges of bit acceptance.

// File: rtl/rzrx_pkg.sv
package rzrx_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned LABEL_W = 8;
  localparam int unsigned IDX_W   = $clog2(WORD_W);
  localparam int unsigned CNT_W   = $clog2(WORD_W + 1);

  typedef logic [WORD_W-1:0] word_t;

  // Minimum pulse length in samples for a given bit period.
  function automatic int unsigned min_pulse(input int unsigned bit_cyc);
    int unsigned q;
    q = bit_cyc / 4;
    return (q == 0) ? 1 : q;
  endfunction

  // NULL length in samples that closes framing.
  function automatic int unsigned gap_len(input int unsigned bit_cyc);
    return 2 * bit_cyc;
  endfunction

  function automatic logic [LABEL_W-1:0] label_flip(input logic [LABEL_W-1:0] v);
    logic [LABEL_W-1:0] r;
    for (int i = 0; i < LABEL_W; i++) r[i] = v[LABEL_W-1-i];
    return r;
  endfunction

  // Odd parity over the whole word: an even count of ones is an error.
  function automatic logic parity_bad(input word_t w);
    return ~(^w);
  endfunction

  function automatic word_t present_word(input word_t raw, input logic nat_order);
    word_t r;
    r = raw;
    if (nat_order) r[LABEL_W-1:0] = label_flip(raw[LABEL_W-1:0]);
    return r;
  endfunction

endpackage

// File: rtl/rzrx_sync.sv
module rzrx_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/rzrx_pulse_det.sv
module rzrx_pulse_det
  import rzrx_pkg::*;
#(
  parameter int unsigned FAST_BIT_CYC = 16,
  parameter int unsigned SLOW_BIT_CYC = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic rate_sel,
  input  logic s_hi,
  input  logic s_lo,
  output logic bit_stb,
  output logic bit_val,
  output logic gap_stb,
  output logic line_fault
);

  localparam int unsigned MAX_GAP = gap_len(SLOW_BIT_CYC > FAST_BIT_CYC ? SLOW_BIT_CYC : FAST_BIT_CYC);
  localparam int unsigned TW      = $clog2(MAX_GAP + 1);

  logic [TW-1:0] min_len, gap_n;
  logic [TW-1:0] run_cnt, run_nx, null_cnt;
  logic          run_pol, armed;
  logic          is_null, is_hi, is_lo, is_both, pulse, same_run, accept, gap_hit;

  always_comb begin
    min_len = rate_sel ? TW'(min_pulse(SLOW_BIT_CYC)) : TW'(min_pulse(FAST_BIT_CYC));
    gap_n   = rate_sel ? TW'(gap_len(SLOW_BIT_CYC))   : TW'(gap_len(FAST_BIT_CYC));
  end

  assign is_null  = !s_hi && !s_lo;
  assign is_hi    =  s_hi && !s_lo;
  assign is_lo    = !s_hi &&  s_lo;
  assign is_both  =  s_hi &&  s_lo;
  assign pulse    = is_hi || is_lo;
  assign same_run = pulse && (run_cnt != '0) && (run_pol == is_lo);

  always_comb begin
    if (!pulse)               run_nx = '0;
    else if (!same_run)       run_nx = TW'(1);
    else if (run_cnt == '1)   run_nx = run_cnt;
    else                      run_nx = run_cnt + TW'(1);
  end

  assign accept  = pulse && armed && (run_nx == min_len);
  assign gap_hit = is_null && (null_cnt == gap_n - TW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt    <= '0;
      run_pol    <= 1'b0;
      armed      <= 1'b0;
      null_cnt   <= '0;
      bit_stb    <= 1'b0;
      bit_val    <= 1'b0;
      gap_stb    <= 1'b0;
      line_fault <= 1'b0;
    end else begin
      run_cnt <= run_nx;
      if (pulse) run_pol <= is_lo;
      if (is_null)     armed <= 1'b1;
      else if (accept) armed <= 1'b0;
      if (!is_null)            null_cnt <= '0;
      else if (null_cnt < gap_n) null_cnt <= null_cnt + TW'(1);
      bit_stb    <= accept;
      bit_val    <= is_hi;
      gap_stb    <= gap_hit;
      line_fault <= is_both;
    end
  end

  // R1: one pulse gives one bit, so strobes never sit back to back
  p_bit_spacing_r1: assert property (@(posedge clk) disable iff (rst) bit_stb |=> !bit_stb)
    else $error("p_bit_spacing_r1");
  // R7: a both-asserted sample never coincides with a taken bit
  p_fault_excl_r7: assert property (@(posedge clk) disable iff (rst) line_fault |-> !bit_stb)
    else $error("p_fault_excl_r7");
  // R8: a gap event is never a bit event
  p_gap_not_bit_r8: assert property (@(posedge clk) disable iff (rst) gap_stb |-> !bit_stb)
    else $error("p_gap_not_bit_r8");

endmodule

// File: rtl/rzrx_assembler.sv
module rzrx_assembler
  import rzrx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  label_nat,
  input  logic  bit_stb,
  input  logic  bit_val,
  input  logic  gap_stb,
  output logic  word_valid,
  output word_t word_q,
  output logic  parity_err,
  output logic  frame_err
);

  logic [CNT_W-1:0] cnt;
  word_t            shreg, filled;
  logic             room;

  assign room = cnt < CNT_W'(WORD_W);

  always_comb begin
    filled = shreg;
    filled[cnt[IDX_W-1:0]] = bit_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      shreg      <= '0;
      word_q     <= '0;
      word_valid <= 1'b0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      frame_err  <= 1'b0;
      if (gap_stb) begin
        cnt <= '0;
      end else if (bit_stb) begin
        if (room) begin
          shreg <= filled;
          cnt   <= cnt + CNT_W'(1);
          if (cnt == CNT_W'(WORD_W - 1)) begin
            word_valid <= 1'b1;
            word_q     <= present_word(filled, label_nat);
            parity_err <= parity_bad(filled);
          end
        end else begin
          frame_err <= 1'b1;
        end
      end
    end
  end

  // R10: the completion strobe lasts one cycle
  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (rst) word_valid |=> !word_valid)
    else $error("p_valid_pulse_r10");
  // R10: the presented word only moves together with the strobe
  p_word_hold_r10: assert property (@(posedge clk) disable iff (rst) !word_valid |-> $stable(word_q))
    else $error("p_word_hold_r10");
  // R9: an overrun bit never completes a word
  p_frame_no_valid_r9: assert property (@(posedge clk) disable iff (rst) frame_err |-> !word_valid)
    else $error("p_frame_no_valid_r9");
  // R2: the bit count never passes the word length
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst) cnt <= CNT_W'(WORD_W))
    else $error("p_cnt_bound_r2");
  // R8: a gap leaves the count at zero
  p_gap_clears_r8: assert property (@(posedge clk) disable iff (rst) gap_stb |=> cnt == '0)
    else $error("p_gap_clears_r8");

endmodule

// File: rtl/rz_word_rx.sv
module rz_word_rx
  import rzrx_pkg::*;
#(
  parameter int unsigned FAST_BIT_CYC = 16,
  parameter int unsigned SLOW_BIT_CYC = 128,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rate_sel,
  input  logic        label_natural,
  input  logic        line_hi,
  input  logic        line_lo,
  output logic        word_valid,
  output logic [31:0] rx_word,
  output logic [7:0]  label,
  output logic [1:0]  sdi,
  output logic [1:0]  ssm,
  output logic        parity_err,
  output logic        frame_err,
  output logic        line_fault
);

  logic [1:0] sync_q;
  logic       bit_stb, bit_val, gap_stb;
  word_t      word_q;

  rzrx_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({line_hi, line_lo}),
    .q   (sync_q)
  );

  rzrx_pulse_det #(.FAST_BIT_CYC(FAST_BIT_CYC), .SLOW_BIT_CYC(SLOW_BIT_CYC)) u_det (
    .clk        (clk),
    .rst        (rst),
    .rate_sel   (rate_sel),
    .s_hi       (sync_q[1]),
    .s_lo       (sync_q[0]),
    .bit_stb    (bit_stb),
    .bit_val    (bit_val),
    .gap_stb    (gap_stb),
    .line_fault (line_fault)
  );

  rzrx_assembler u_asm (
    .clk        (clk),
    .rst        (rst),
    .label_nat  (label_natural),
    .bit_stb    (bit_stb),
    .bit_val    (bit_val),
    .gap_stb    (gap_stb),
    .word_valid (word_valid),
    .word_q     (word_q),
    .parity_err (parity_err),
    .frame_err  (frame_err)
  );

  assign rx_word = word_q;
  assign label   = word_q[LABEL_W-1:0];
  assign sdi     = word_q[9:8];
  assign ssm     = word_q[30:29];

endmodule

// File: tb/tb_rz_word_rx.sv
module tb_rz_word_rx;

  localparam int CLK_PERIOD = 10;
  localparam int FAST = 16;
  localparam int SLOW = 128;

  logic clk = 1'b0;
  logic rst, rate_sel, label_natural, line_hi, line_lo;
  logic word_valid, parity_err, frame_err, line_fault;
  logic [31:0] rx_word;
  logic [7:0] label;
  logic [1:0] sdi, ssm;

  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rz_word_rx dut (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .label_natural(label_natural),
    .line_hi(line_hi), .line_lo(line_lo), .word_valid(word_valid), .rx_word(rx_word),
    .label(label), .sdi(sdi), .ssm(ssm), .parity_err(parity_err),
    .frame_err(frame_err), .line_fault(line_fault)
  );

  function automatic logic [31:0] exp_present(input logic [31:0] w, input logic nat);
    logic [31:0] r;
    r = w;
    if (nat) for (int i = 0; i < 8; i++) r[7-i] = w[i];
    return r;
  endfunction

  function automatic logic [31:0] make_word(input logic [31:0] base, input logic want_odd);
    logic [31:0] w;
    w = base;
    w[31] = 1'b0;
    if (($countones(w) % 2 == 1) != want_odd) w[31] = 1'b1;
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic m_h1, m_h2, m_l1, m_l2;
  int   m_run, m_null, m_cnt;
  logic m_pol, m_armed, p_bit, p_val, p_gap;
  logic [31:0] m_buf;
  logic e_valid, e_ferr, e_fault, e_perr;
  logic [31:0] e_word;
  bit live = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_h1 = 0; m_h2 = 0; m_l1 = 0; m_l2 = 0;
      m_run = 0; m_null = 0; m_cnt = 0; m_pol = 0; m_armed = 0;
      p_bit = 0; p_val = 0; p_gap = 0; m_buf = '0;
      e_valid = 0; e_ferr = 0; e_fault = 0; e_perr = 0; e_word = '0;
    end else begin
      logic h, l;
      int bitlen, minp, gapn;
      e_valid = 0; e_ferr = 0;
      if (p_gap) m_cnt = 0;
      else if (p_bit) begin
        if (m_cnt < 32) begin
          m_buf[m_cnt] = p_val;
          m_cnt++;
          if (m_cnt == 32) begin
            e_valid = 1;
            e_word  = exp_present(m_buf, label_natural);
            e_perr  = ($countones(m_buf) % 2 == 0);
          end
        end else e_ferr = 1;
      end
      h = m_h2; l = m_l2;
      m_h2 = m_h1; m_l2 = m_l1; m_h1 = line_hi; m_l1 = line_lo;
      bitlen = rate_sel ? SLOW : FAST;
      minp = bitlen / 4;
      gapn = 2 * bitlen;
      e_fault = h && l;
      p_bit = 0; p_gap = 0;
      if (h != l) begin
        if (m_run > 0 && m_pol == l) m_run++;
        else begin m_run = 1; m_pol = l; end
        if (m_armed && m_run == minp) begin p_bit = 1; p_val = h; m_armed = 0; end
      end else begin
        m_run = 0;
        if (!h) m_armed = 1;
      end
      if (!h && !l) begin
        if (m_null == gapn - 1) p_gap = 1;
        if (m_null < gapn) m_null++;
      end else m_null = 0;
    end
  end

  // ---------------- per-cycle comparison and capture ----------------
  logic [31:0] cap_w[$];
  logic        cap_p[$];
  logic [7:0]  cap_lab[$];
  logic [1:0]  cap_sdi[$], cap_ssm[$];
  int ferr_seen = 0, fault_seen = 0, vrun = 0, vrun_max = 0;

  always @(negedge clk) begin
    if (live) begin
      compared++;
      if (word_valid !== e_valid) begin mismatched++; $display("FAIL R10 word_valid got %0b exp %0b", word_valid, e_valid); end
      if (rx_word !== e_word)     begin mismatched++; $display("FAIL R2 rx_word got %h exp %h", rx_word, e_word); end
      if (label !== e_word[7:0])  begin mismatched++; $display("FAIL R3 label got %h exp %h", label, e_word[7:0]); end
      if (sdi !== e_word[9:8] || ssm !== e_word[30:29]) begin
        mismatched++; $display("FAIL R5 sdi/ssm got %b/%b exp %b/%b", sdi, ssm, e_word[9:8], e_word[30:29]);
      end
      if (parity_err !== e_perr)  begin mismatched++; $display("FAIL R4 parity_err got %0b exp %0b", parity_err, e_perr); end
      if (frame_err !== e_ferr)   begin mismatched++; $display("FAIL R9 frame_err got %0b exp %0b", frame_err, e_ferr); end
      if (line_fault !== e_fault) begin mismatched++; $display("FAIL R7 line_fault got %0b exp %0b", line_fault, e_fault); end
      if (word_valid) begin
        cap_w.push_back(rx_word); cap_p.push_back(parity_err); cap_lab.push_back(label);
        cap_sdi.push_back(sdi); cap_ssm.push_back(ssm);
      end
      if (frame_err) ferr_seen++;
      if (line_fault) fault_seen++;
      vrun = word_valid ? vrun + 1 : 0;
      if (vrun > vrun_max) vrun_max = vrun;
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    line_hi = 0; line_lo = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic tx_bit(input logic b, input int bc);
    line_hi = b; line_lo = !b;
    repeat (bc/2) @(negedge clk);
    idle(bc/2);
  endtask

  task automatic tx_word(input logic [31:0] w, input int nbits, input int bc);
    for (int i = 0; i < nbits; i++) tx_bit(w[i % 32], bc);
    idle(4 * bc);
  endtask

  task automatic expect_one(input logic [31:0] w, input logic nat, input int n0, input string tag);
    logic [31:0] ew;
    ew = exp_present(w, nat);
    chk(cap_w.size() == n0 + 1, {tag, " word count"}, 32'(cap_w.size()), 32'(n0 + 1));
    if (cap_w.size() == n0 + 1) begin
      chk(cap_w[$] == ew, {tag, " word"}, cap_w[$], ew);
      chk(cap_lab[$] == ew[7:0], {tag, " R3 label"}, 32'(cap_lab[$]), 32'(ew[7:0]));
      chk(cap_p[$] == ($countones(w) % 2 == 0), {tag, " R4 parity"}, 32'(cap_p[$]), 32'($countones(w) % 2 == 0));
      chk(cap_sdi[$] == w[9:8] && cap_ssm[$] == w[30:29], {tag, " R5 fields"},
          {28'd0, cap_ssm[$], cap_sdi[$]}, {28'd0, w[30:29], w[9:8]});
    end
  endtask

  initial begin
    logic [31:0] wa, wb, wc, wd, we, wf;
    int n0, f0;
    rst = 1; rate_sel = 0; label_natural = 0; line_hi = 0; line_lo = 0;
    repeat (4) @(negedge clk);
    // R11: reset state
    chk(word_valid == 0 && rx_word == 0 && parity_err == 0 && frame_err == 0 && line_fault == 0,
        "R11 reset outputs", rx_word, 32'd0);
    rst = 0; live = 1;
    // R11: a pulse already present at reset release (no NULL yet) yields nothing
    line_hi = 1; repeat (8) @(negedge clk);
    idle(80);
    chk(cap_w.size() == 0, "R11 no bit before NULL", 32'(cap_w.size()), 32'd0);

    wa = make_word(32'h2345_6789, 1'b1);
    n0 = cap_w.size(); tx_word(wa, 32, FAST); expect_one(wa, 0, n0, "R2 fast raw");

    wb = make_word(32'h5A3C_0DE1, 1'b1);
    label_natural = 1;
    n0 = cap_w.size(); tx_word(wb, 32, FAST); expect_one(wb, 1, n0, "R3 natural label");
    label_natural = 0;

    wc = make_word(32'h1F00_03B6, 1'b0);
    n0 = cap_w.size(); tx_word(wc, 32, FAST); expect_one(wc, 0, n0, "R4 even parity");

    // R1: pulses one sample short of the minimum are ignored
    n0 = cap_w.size();
    for (int k = 0; k < 40; k++) begin
      line_hi = 1; repeat (FAST/4 - 1) @(negedge clk); idle(FAST/2);
    end
    idle(4 * FAST);
    chk(cap_w.size() == n0, "R1 short pulses ignored", 32'(cap_w.size()), 32'(n0));
    wd = make_word(32'h0ACE_5F27, 1'b1);
    tx_word(wd, 32, FAST); expect_one(wd, 0, n0, "R1 word after glitches");

    // R7: both inputs asserted
    f0 = fault_seen; n0 = cap_w.size();
    line_hi = 1; line_lo = 1; repeat (5) @(negedge clk); idle(4 * FAST);
    chk(fault_seen == f0 + 5, "R7 fault cycles", 32'(fault_seen - f0), 32'd5);
    chk(cap_w.size() == n0, "R7 no word from fault", 32'(cap_w.size()), 32'(n0));

    // R8: fragment then full word
    we = make_word(32'h7E81_4C3A, 1'b0);
    n0 = cap_w.size();
    tx_word(32'hFFFF_FFFF, 20, FAST);
    chk(cap_w.size() == n0, "R8 fragment dropped", 32'(cap_w.size()), 32'(n0));
    tx_word(we, 32, FAST); expect_one(we, 0, n0, "R8 word after fragment");

    // R9: 34 bits with no gap
    f0 = ferr_seen; n0 = cap_w.size();
    tx_word(wa, 34, FAST);
    chk(ferr_seen == f0 + 2, "R9 frame_err pulses", 32'(ferr_seen - f0), 32'd2);
    expect_one(wa, 0, n0, "R9 first 32 kept");

    // R6: slow rate
    rate_sel = 1; idle(8);
    n0 = cap_w.size();
    tx_word(wb, 32, FAST);
    chk(cap_w.size() == n0, "R6 fast pulses ignored at slow rate", 32'(cap_w.size()), 32'(n0));
    wf = make_word(32'h3C96_A501, 1'b1);
    tx_word(wf, 32, SLOW); expect_one(wf, 0, n0, "R6 slow word");
    rate_sel = 0; idle(8);
    n0 = cap_w.size(); tx_word(wc, 32, FAST); expect_one(wc, 0, n0, "R6 back to fast");

    // R10: strobe width and hold
    chk(vrun_max == 1, "R10 strobe width", 32'(vrun_max), 32'd1);
    chk(rx_word == exp_present(wc, 0), "R10 word held", rx_word, exp_present(wc, 0));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule